// File: doc/BRIEF.md
# Segment-Wrapping Serial Memory Address Generator

This block sits behind the byte deserialiser of a serial flash memory. Once the command decoder has gathered the four address bytes that follow an opcode, it presents them together with a one-cycle load pulse. The block then builds a 21-bit byte address from bit fields spread across those bytes. It also records whether the transfer is a read or a page program. After that it holds the address steady, except that each data byte moved across the serial link advances it by one.

The two modes wrap at different boundaries. A read steps the low nine bits and wraps inside a 512-byte segment. A page program steps the low seven bits and wraps inside a 128-byte page. The bits above the counting field do not change for the whole transfer. Raising chip select ends the transfer. The sector, segment and page numbers are brought out as separate fields for the array decoder.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr` is 0, `active` is 0 and the latched mode is read.
- R2: A `load` pulse with `cs_n` low latches the address in one cycle and sets `active`. The mapping is: `addr[20:17]` = `hi_byte[3:0]`, `addr[16:9]` = `mid_byte[7:0]`, `addr[8:7]` = `lo_byte[1:0]` and `addr[6:0]` = `off_byte[6:0]`.
- R3: Bits `hi_byte[7:4]`, `lo_byte[7:2]` and `off_byte[7]` have no effect on `addr`.
- R4: In read mode (`prog_mode` = 0 at load), each `step` while active adds one to `addr[8:0]`, modulo 512. `addr[20:9]` is unchanged, so 511 is followed by 0 of the same segment.
- R5: In program mode (`prog_mode` = 1 at load), each `step` while active adds one to `addr[6:0]`, modulo 128. `addr[20:7]` is unchanged. The mode is taken only at load, and later changes of `prog_mode` have no effect.
- R6: The wrap point depends only on the mode and not on the starting offset. A transfer that starts at any offset wraps at the last byte of its segment or page.
- R7: `cs_n` high clears `active` in the next cycle. While `active` is 0, `step` leaves `addr` unchanged.
- R8: When `load` and `step` come in the same cycle, the freshly loaded address is taken and the step is dropped.
- R9: `load` while `cs_n` is high is ignored: `addr` and `active` are unchanged.
- R10: `sector` = `addr[20:13]`, `segment` = `addr[20:9]` and `page` = `addr[20:7]` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| hi_byte | input | 8 | First address byte (bits 3:0 used) |
| mid_byte | input | 8 | Second address byte |
| lo_byte | input | 8 | Third address byte (bits 1:0 used) |
| off_byte | input | 8 | Byte-offset byte (bits 6:0 used) |
| load | input | 1 | Latch all address bytes and start a transfer |
| prog_mode | input | 1 | 1 = page program wrap, 0 = segment read wrap |
| step | input | 1 | Advance by one byte |
| addr | output | 21 | Current byte address |
| sector | output | 8 | Sector number |
| segment | output | 12 | Segment number |
| page | output | 14 | Page number |
| active | output | 1 | A transfer is in progress |

## Verification
The assertions check on every cycle the rules that relate one cycle to the next:
- The field mapping of a load.
- The frozen upper bits and the modular increment in each mode.
- The clearing of `active` by chip select, and the hold of the address while inactive.

Other behaviours need whole scenarios, so only the bench shows them:
- A full trip around a segment or page from an odd start offset.
- Mode changes after load being ignored.
- A load that arrives with chip select high.
- The reset state.

The bench checks these against a behavioural model on every clock.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int AW     = 21,
  parameter int SEG_W  = 9,
  parameter int PAGE_W = 7,
  parameter int SECT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic [7:0]           hi_byte,
  input  logic [7:0]           mid_byte,
  input  logic [7:0]           lo_byte,
  input  logic [7:0]           off_byte,
  input  logic                 load,
  input  logic                 prog_mode,
  input  logic                 step,
  output logic [AW-1:0]        addr,
  output logic [SECT_W-1:0]    sector,
  output logic [AW-SEG_W-1:0]  segment,
  output logic [AW-PAGE_W-1:0] page,
  output logic                 active
);
  localparam int MID_W = 8;
  localparam int LO_W  = SEG_W - PAGE_W;
  localparam int HI_W  = AW - SEG_W - MID_W;
  localparam logic [AW-1:0] SEG_MASK  = AW'((1 << SEG_W) - 1);
  localparam logic [AW-1:0] PAGE_MASK = AW'((1 << PAGE_W) - 1);

  logic          prog_q;
  logic [AW-1:0] load_val, mask, stepped;

  assign load_val = {hi_byte[HI_W-1:0], mid_byte[MID_W-1:0],
                     lo_byte[LO_W-1:0], off_byte[PAGE_W-1:0]};
  assign mask     = prog_q ? PAGE_MASK : SEG_MASK;
  assign stepped  = (addr & ~mask) | ((addr + AW'(1)) & mask);

  wire unused_bits = ^{hi_byte[7:HI_W], lo_byte[7:LO_W], off_byte[7:PAGE_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      active <= 1'b0;
      prog_q <= 1'b0;
    end else if (cs_n) begin
      active <= 1'b0;
    end else if (load) begin
      addr   <= load_val;
      active <= 1'b1;
      prog_q <= prog_mode;
    end else if (step && active) begin
      addr   <= stepped;
    end
  end

  assign sector  = addr[AW-1 -: SECT_W];
  assign segment = addr[AW-1:SEG_W];
  assign page    = addr[AW-1:PAGE_W];
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int AW     = 21,
  parameter int SEG_W  = 9,
  parameter int PAGE_W = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic [7:0]    hi_byte,
  input logic [7:0]    mid_byte,
  input logic [7:0]    lo_byte,
  input logic [7:0]    off_byte,
  input logic          load,
  input logic          step,
  input logic          prog_q,
  input logic [AW-1:0] addr,
  input logic          active
);
  localparam int LO_W = SEG_W - PAGE_W;
  localparam int HI_W = AW - SEG_W - 8;

  // R2
  load_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !cs_n) |=> (active && addr == {$past(hi_byte[HI_W-1:0]), $past(mid_byte),
                                            $past(lo_byte[LO_W-1:0]), $past(off_byte[PAGE_W-1:0])}));

  // R4
  read_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !load && step && active && !prog_q) |=>
      (addr[AW-1:SEG_W] == $past(addr[AW-1:SEG_W]) &&
       addr[SEG_W-1:0] == SEG_W'($past(addr[SEG_W-1:0]) + 1'b1)));

  // R5
  prog_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !load && step && active && prog_q) |=>
      (addr[AW-1:PAGE_W] == $past(addr[AW-1:PAGE_W]) &&
       addr[PAGE_W-1:0] == PAGE_W'($past(addr[PAGE_W-1:0]) + 1'b1)));

  // R7
  cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !active);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(load && !cs_n)) |=> $stable(addr));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.AW(AW), .SEG_W(SEG_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hi_byte(hi_byte), .mid_byte(mid_byte),
  .lo_byte(lo_byte), .off_byte(off_byte), .load(load), .step(step),
  .prog_q(prog_q), .addr(addr), .active(active)
);

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, ld = 1'b0, pm = 1'b0, stp = 1'b0;
  logic [7:0] b_hi = 0, b_mid = 0, b_lo = 0, b_off = 0;
  logic [20:0] addr;
  logic [7:0]  sector;
  logic [11:0] segment;
  logic [13:0] page;
  logic        active;

  int vectors = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  int  m_addr = 0;
  bit  m_act = 0, m_prog = 0;

  always #5 clk = ~clk;

  seg_addr_gen u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hi_byte(b_hi), .mid_byte(b_mid),
    .lo_byte(b_lo), .off_byte(b_off), .load(ld), .prog_mode(pm), .step(stp),
    .addr(addr), .sector(sector), .segment(segment), .page(page), .active(active));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_act = 0; m_prog = 0;
    end else if (cs_n) begin
      m_act = 0;
    end else if (ld) begin
      m_addr = (b_hi % 16) * 131072 + b_mid * 512 + (b_lo % 4) * 128 + (b_off % 128);
      m_act = 1; m_prog = pm;
    end else if (stp && m_act) begin
      if (m_prog) m_addr = m_addr - m_addr % 128 + (m_addr % 128 + 1) % 128;
      else        m_addr = m_addr - m_addr % 512 + (m_addr % 512 + 1) % 512;
    end
  end

  task automatic report(string req, int got, int exp);
    vectors++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic compare();
    report(cur_req, int'(addr), m_addr);
    report(cur_req, int'(active), int'(m_act));
    // R10
    report("R10", int'(sector), m_addr / 8192);
    report("R10", int'(segment), m_addr / 512);
    report("R10", int'(page), m_addr / 128);
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic load_addr(input int hi, input int mid, input int lo, input int off, input bit prog);
    b_hi = 8'(hi); b_mid = 8'(mid); b_lo = 8'(lo); b_off = 8'(off); pm = prog; ld = 1;
    cyc();
    ld = 0;
  endtask

  task automatic steps(input int n);
    stp = 1;
    for (int i = 0; i < n; i++) cyc();
    stp = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    int base;
    cur_req = "R1";
    @(negedge clk);
    stp = 1; ld = 1; cs_n = 0;
    cyc(); cyc();
    report("R1", int'(addr), 0);
    report("R1", int'(active), 0);
    stp = 0; ld = 0;
    rst_n = 1;
    cyc();

    cur_req = "R2";
    load_addr(8'h03, 8'hA5, 8'h02, 8'h10, 0);
    base = 3 * 131072 + 165 * 512;
    report("R2", int'(addr), base + 256 + 16);
    cur_req = "R4";
    steps(520);
    report("R4", int'(addr), base + (272 + 520) % 512);

    cur_req = "R3";
    load_addr(8'hF5, 8'h3C, 8'hFD, 8'hFF, 0);
    report("R3", int'(addr), 5 * 131072 + 60 * 512 + 128 + 127);

    cur_req = "R6";
    load_addr(8'h01, 8'h02, 8'h03, 8'h7F, 0);
    base = 131072 + 2 * 512;
    steps(1);
    report("R6", int'(addr), base);

    cur_req = "R5";
    load_addr(8'h0A, 8'h77, 8'h01, 8'h7D, 1);
    base = 10 * 131072 + 119 * 512 + 128;
    pm = 0;
    steps(3);
    report("R5", int'(addr), base);
    steps(130);
    report("R5", int'(addr), base + 2);

    cur_req = "R8";
    b_hi = 8'h02; b_mid = 8'h11; b_lo = 8'h00; b_off = 8'h05; pm = 0; ld = 1; stp = 1;
    cyc();
    ld = 0; stp = 0;
    report("R8", int'(addr), 2 * 131072 + 17 * 512 + 5);

    cur_req = "R7";
    cs_n = 1;
    cyc();
    report("R7", int'(active), 0);
    steps(4);
    report("R7", int'(addr), 2 * 131072 + 17 * 512 + 5);

    cur_req = "R9";
    load_addr(8'h0F, 8'hFF, 8'h03, 8'h7F, 1);
    report("R9", int'(addr), 2 * 131072 + 17 * 512 + 5);
    report("R9", int'(active), 0);

    cur_req = "R7";
    cs_n = 0;
    steps(3);
    report("R7", int'(addr), 2 * 131072 + 17 * 512 + 5);

    cur_req = "R4";
    load_addr(8'h0F, 8'hFF, 8'h03, 8'h7E, 0);
    steps(2);
    report("R4", int'(addr), 15 * 131072 + 255 * 512);
    report("R10", int'(sector), 15 * 16 + 15);

    cs_n = 1;
    cyc();
    finish_up();
  end
endmodule